// File: doc/BRIEF.md
# RV32 Instruction Format Field Decoder

This combinational block accepts one 32-bit RV32 instruction word and works out which encoding format it uses by looking only at the 7-bit opcode. The recognised formats are R, I, S, SB and UJ. The block reports the format as a one-hot vector, with a separate flag for any opcode outside the recognised set.

Alongside the format, the block splits the word into its fixed fields: opcode, destination register, both source registers, funct3 and funct7. These fields are presented on every cycle, whatever the format.

It also rebuilds the immediate for the detected format, because the immediate bits are scattered differently in each encoding. The immediate is offered in two forms: a raw zero-padded value and a sign-extended value. A datapath places the block straight after instruction fetch and picks whichever outputs the current format makes meaningful.

Top module: `rvfd_decode`

## Requirements
- R1: `opcode` equals instr[6:0], `rd` equals instr[11:7], `funct3` equals instr[14:12], `rs1` equals instr[19:15], `rs2` equals instr[24:20] and `funct7` equals instr[31:25], for every instruction word including unknown ones.
- R2: Opcode 7'h33 sets only `fmt_onehot` bit 0 (R format). In that case `imm_raw` and `imm_sext` are both zero.
- R3: Opcodes 7'h03 and 7'h13 set only `fmt_onehot` bit 1 (I format). In that case `imm_raw[11:0]` equals instr[31:20].
- R4: Opcode 7'h23 sets only `fmt_onehot` bit 2 (S format). In that case `imm_raw[11:0]` equals {instr[31:25], instr[11:7]}.
- R5: Opcode 7'h63 sets only `fmt_onehot` bit 3 (SB format). In that case `imm_raw` bits 11, 10, 9:4 and 3:0 take instr[31], instr[7], instr[30:25] and instr[11:8] respectively.
- R6: Opcode 7'h6F sets only `fmt_onehot` bit 4 (UJ format). In that case `imm_raw[19:0]` equals {instr[31], instr[19:12], instr[20], instr[30:21]}.
- R7: Any other opcode raises `fmt_unknown` and clears all of `fmt_onehot`, `imm_raw` and `imm_sext`.
- R8: At most one bit of `fmt_onehot` is set. `fmt_unknown` is 1 exactly when no bit of `fmt_onehot` is set.
- R9: For I, S and SB, `imm_sext` holds the 12-bit assembled immediate with instr[31] copied into every higher bit. For UJ, it holds the 20-bit value with instr[31] copied above bit 19.
- R10: All `imm_raw` bits above the width of the assembled immediate are zero (above bit 11 for I, S and SB).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word under decode |
| fmt_onehot | output | 5 | Format vector: bit0 R, bit1 I, bit2 S, bit3 SB, bit4 UJ |
| fmt_unknown | output | 1 | Opcode outside the recognised set |
| opcode | output | 7 | instr[6:0] |
| rd | output | 5 | Destination register field |
| rs1 | output | 5 | First source register field |
| rs2 | output | 5 | Second source register field |
| funct3 | output | 3 | Minor function field |
| funct7 | output | 7 | Major function field |
| imm_raw | output | 20 | Assembled immediate, zero above its width |
| imm_sext | output | IMM_W (32) | Assembled immediate sign-extended from instr[31] |

## Verification
Field slicing and immediate assembly read the same instruction bits at the same time. In an S or SB word, bits 11:7 serve as the rd field and also as part of the immediate. Walking a single one through every bit above the opcode, under each recognised opcode, shows whether both uses of a shared bit react in the same vector. The rest of the 128-opcode sweep uses all-zero, all-one and scrambled upper bits, so that the classifier's verdict and the immediate's sign fill are judged together against values the bench computes arithmetically.

// File: rtl/rvfd_pkg.sv
package rvfd_pkg;
   localparam int INSTR_W = 32;
   localparam int OPC_W   = 7;
   localparam int REG_W   = 5;
   localparam int FMT_N   = 5;
   localparam int RAW_W   = 20;
   localparam int SHORT_W = 12;

   localparam int FMT_R  = 0;
   localparam int FMT_I  = 1;
   localparam int FMT_S  = 2;
   localparam int FMT_SB = 3;
   localparam int FMT_UJ = 4;

   localparam int OPC_N = 6;

   typedef struct packed {
      logic [OPC_W-1:0] code;
      logic [2:0]       cls;
   } opc_entry_t;

   function automatic opc_entry_t opc_table(input int k);
      opc_entry_t e;
      case (k)
         0:       e = '{code: 7'h33, cls: 3'(FMT_R)};
         1:       e = '{code: 7'h03, cls: 3'(FMT_I)};
         2:       e = '{code: 7'h13, cls: 3'(FMT_I)};
         3:       e = '{code: 7'h23, cls: 3'(FMT_S)};
         4:       e = '{code: 7'h63, cls: 3'(FMT_SB)};
         default: e = '{code: 7'h6F, cls: 3'(FMT_UJ)};
      endcase
      return e;
   endfunction

   typedef struct packed {
      logic [6:0]       f7;
      logic [REG_W-1:0] s2;
      logic [REG_W-1:0] s1;
      logic [2:0]       f3;
      logic [REG_W-1:0] d;
      logic [OPC_W-1:0] op;
   } field_set_t;
endpackage

// File: rtl/rvfd_classify.sv
module rvfd_classify
   import rvfd_pkg::*;
#(
   parameter int N_FMT = FMT_N
) (
   input  logic [OPC_W-1:0] opc,
   output logic [N_FMT-1:0] fmt,
   output logic             unknown
);
   logic [OPC_N-1:0] hit;

   generate
      for (genvar k = 0; k < OPC_N; k++) begin : g_match
         localparam opc_entry_t ENT = opc_table(k);
         assign hit[k] = (opc == ENT.code);
      end
   endgenerate

   always_comb begin
      fmt = '0;
      for (int k = 0; k < OPC_N; k++) begin
         if (hit[k]) fmt[opc_table(k).cls] = 1'b1;
      end
   end

   assign unknown = ~|hit;

   generate
      if (N_FMT != FMT_N) begin : g_bad_n
         $error("rvfd_classify: N_FMT must equal FMT_N");
      end
   endgenerate
endmodule

// File: rtl/rvfd_fields.sv
module rvfd_fields
   import rvfd_pkg::*;
(
   input  logic [INSTR_W-1:0] word,
   output field_set_t         flds
);
   assign flds = field_set_t'(word);
endmodule

// File: rtl/rvfd_imm.sv
module rvfd_imm
   import rvfd_pkg::*;
#(
   parameter int OUT_W = 32
) (
   input  logic [INSTR_W-1:0] word,
   input  logic [FMT_N-1:0]   fmt,
   output logic [RAW_W-1:0]   raw,
   output logic [OUT_W-1:0]   sext
);
   localparam int PAD_S = OUT_W - SHORT_W;
   localparam int PAD_L = OUT_W - RAW_W;

   logic [SHORT_W-1:0] i_val, s_val, b_val;
   logic [RAW_W-1:0]   j_val;
   logic               sgn;

   assign sgn   = word[INSTR_W-1];
   assign i_val = word[31:20];
   assign s_val = {word[31:25], word[11:7]};
   assign b_val = {word[31], word[7], word[30:25], word[11:8]};
   assign j_val = {word[31], word[19:12], word[20], word[30:21]};

   always_comb begin
      raw  = '0;
      sext = '0;
      unique case (1'b1)
         fmt[FMT_I]:  begin raw = RAW_W'(i_val); sext = {{PAD_S{sgn}}, i_val}; end
         fmt[FMT_S]:  begin raw = RAW_W'(s_val); sext = {{PAD_S{sgn}}, s_val}; end
         fmt[FMT_SB]: begin raw = RAW_W'(b_val); sext = {{PAD_S{sgn}}, b_val}; end
         fmt[FMT_UJ]: begin raw = j_val;         sext = {{PAD_L{sgn}}, j_val}; end
         default:     begin raw = '0;            sext = '0; end
      endcase
   end

   generate
      if (OUT_W <= RAW_W) begin : g_bad_w
         $error("rvfd_imm: OUT_W must exceed the widest immediate");
      end
   endgenerate
endmodule

// File: rtl/rvfd_decode.sv
module rvfd_decode
   import rvfd_pkg::*;
#(
   parameter int IMM_W = 32
) (
   input  logic [31:0]      instr,
   output logic [4:0]       fmt_onehot,
   output logic             fmt_unknown,
   output logic [6:0]       opcode,
   output logic [4:0]       rd,
   output logic [4:0]       rs1,
   output logic [4:0]       rs2,
   output logic [2:0]       funct3,
   output logic [6:0]       funct7,
   output logic [19:0]      imm_raw,
   output logic [IMM_W-1:0] imm_sext
);
   field_set_t flds;

   rvfd_classify #(.N_FMT(FMT_N)) u_cls (
      .opc     (instr[OPC_W-1:0]),
      .fmt     (fmt_onehot),
      .unknown (fmt_unknown)
   );

   rvfd_fields u_fld (
      .word (instr),
      .flds (flds)
   );

   rvfd_imm #(.OUT_W(IMM_W)) u_imm (
      .word (instr),
      .fmt  (fmt_onehot),
      .raw  (imm_raw),
      .sext (imm_sext)
   );

   assign opcode = flds.op;
   assign rd     = flds.d;
   assign rs1    = flds.s1;
   assign rs2    = flds.s2;
   assign funct3 = flds.f3;
   assign funct7 = flds.f7;

   always_comb begin
      a_r8_onehot: assert ($onehot0(fmt_onehot));
      a_r8_unknown_excl: assert (fmt_unknown == (fmt_onehot == '0));
      a_r7_clear: assert (!fmt_unknown || (imm_raw == '0 && imm_sext == '0));
      a_r2_rtype_zero: assert (!fmt_onehot[FMT_R] || imm_sext == '0);
      a_r9_sign_top: assert (fmt_unknown || fmt_onehot[FMT_R]
                             || imm_sext[IMM_W-1] == instr[31]);
      a_r10_short_pad: assert (!(fmt_onehot[FMT_I] || fmt_onehot[FMT_S] || fmt_onehot[FMT_SB])
                               || imm_raw[19:12] == '0);
   end
endmodule

// File: tb/rvfd_decode_tb.sv
module rvfd_decode_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = 32'h0;
   logic [4:0]  fmt_onehot;
   logic        fmt_unknown;
   logic [6:0]  opcode, funct7;
   logic [4:0]  rd, rs1, rs2;
   logic [2:0]  funct3;
   logic [19:0] imm_raw;
   logic [31:0] imm_sext;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   rvfd_decode #(.IMM_W(32)) u_dut (
      .instr(instr), .fmt_onehot(fmt_onehot), .fmt_unknown(fmt_unknown),
      .opcode(opcode), .rd(rd), .rs1(rs1), .rs2(rs2), .funct3(funct3),
      .funct7(funct7), .imm_raw(imm_raw), .imm_sext(imm_sext)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s instr=%h actual=%h expected=%h", req, instr, act, exp);
      end
   endtask

   function automatic int exp_cls(input logic [6:0] op);
      case (op)
         7'h33:        return 0;
         7'h03, 7'h13: return 1;
         7'h23:        return 2;
         7'h63:        return 3;
         7'h6F:        return 4;
         default:      return -1;
      endcase
   endfunction

   function automatic logic [31:0] bitv(input logic [31:0] v, input int p);
      return (v >> p) & 32'h1;
   endfunction

   task automatic apply_and_check(input logic [31:0] v);
      int          c;
      int          w;
      logic [31:0] raw, sx, fields;
      string       tag;
      @(negedge clk);
      instr = v;
      @(posedge clk);
      #1;
      c = exp_cls(v[6:0]);
      raw = 0; w = 0;
      case (c)
         1: begin raw = (v >> 20) & 32'hFFF; w = 12; end
         2: begin raw = (((v >> 25) & 32'h7F) << 5) + ((v >> 7) & 32'h1F); w = 12; end
         3: begin raw = (bitv(v,31) << 11) + (bitv(v,7) << 10)
                        + (((v >> 25) & 32'h3F) << 4) + ((v >> 8) & 32'hF); w = 12; end
         4: begin raw = (bitv(v,31) << 19) + (((v >> 12) & 32'hFF) << 11)
                        + (bitv(v,20) << 10) + ((v >> 21) & 32'h3FF); w = 20; end
         default: begin raw = 0; w = 0; end
      endcase
      sx = raw;
      if (w != 0 && v[31]) sx = raw | ~((32'h1 << w) - 32'h1);
      case (c)
         0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4";
         3: tag = "R5"; 4: tag = "R6"; default: tag = "R7";
      endcase
      fields = {funct7, rs2, rs1, funct3, rd, opcode};
      chk("R1 fields", fields, v);
      chk({tag, " fmt"}, {27'h0, fmt_onehot}, (c < 0) ? 32'h0 : (32'h1 << c));
      chk("R8 unknown", {31'h0, fmt_unknown}, (c < 0) ? 32'h1 : 32'h0);
      chk({tag, " R10 raw"}, {12'h0, imm_raw}, raw);
      chk({tag, " R9 sext"}, imm_sext, sx);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [6:0] ops [6];
      ops = '{7'h33, 7'h03, 7'h13, 7'h23, 7'h63, 7'h6F};
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset/idle state: all-zero word is an unknown opcode (R7)
      #1;
      chk("R7 idle unknown", {31'h0, fmt_unknown}, 32'h1);
      chk("R7 idle imm", imm_sext, 32'h0);
      // opcode sweep with varied upper bits (R1..R10)
      for (int op = 0; op < 128; op++) begin
         for (int p = 0; p < 8; p++) begin
            logic [31:0] x;
            if (p == 0)      x = 32'h0;
            else if (p == 1) x = 32'hFFFF_FFFF;
            else             x = (32'(p) * 32'h9E37_79B9) ^ (32'(op) * 32'h85EB_CA6B);
            apply_and_check({x[31:7], 7'(op)});
         end
      end
      // walking one through shared bits for each recognised opcode (R3..R6)
      for (int k = 0; k < 6; k++) begin
         for (int b = 7; b < 32; b++) begin
            logic [31:0] v;
            v = (32'h1 << b) | {25'h0, ops[k]};
            apply_and_check(v);
         end
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule